// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a warp's load/store issue and the memory side. It receives, in one handshake, the 32 word addresses of a single warp memory instruction together with a mask of active lanes. It groups the active lanes by the 128-byte aligned segment their word falls in. It then sends one transaction per touched segment on a valid/ready output channel.

Each transaction carries the byte address of its segment and a 128-bit byte-enable map. Bits 4*w to 4*w+3 of the map stand for word w of the segment. A warp whose lanes read 32 consecutive words from an aligned base needs one transaction. A run that crosses a segment boundary needs two. Fully scattered addresses need one transaction per lane.

The block takes no new instruction until the last transaction of the current one has been accepted. It marks that point with a one-cycle done pulse.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `txn_valid` and `done` are 0 and `req_ready` is 1.
- R2: An instruction is taken on a clock edge where `req_valid` and `req_ready` are both 1. From then until its last transaction has been accepted, `req_ready` is 0.
- R3: Thirty-two active lanes whose word addresses are consecutive and start on a 32-word boundary produce exactly one transaction, with all 128 byte enables set.
- R4: Thirty-two consecutive active words whose run crosses a 32-word boundary produce exactly two transactions.
- R5: Lane word address bits [4:0] select the word within a segment. Each active lane in a transaction sets enable bits 4*w to 4*w+3, where w is that word. Lanes that share a segment, including lanes with the same address, are merged into one transaction.
- R6: Inactive lanes add no transaction and no byte enable. An instruction with an all-zero mask produces no transaction, only the done pulse.
- R7: Transactions leave in the order of the lowest-numbered not-yet-sent active lane, and each touched segment appears exactly once.
- R8: While `txn_valid` is 1 and `txn_ready` is 0, `txn_base` and `txn_be` hold their values and `txn_valid` stays 1.
- R9: `done` is 1 for the single cycle that follows the edge on which the last transaction was accepted. For an empty mask, it follows the accepting edge of the instruction instead.
- R10: `txn_base` is the byte address of the segment: the lane word address shifted left by 2, with byte address bits [6:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction present |
| req_ready | output | 1 | Block can take an instruction |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| req_waddr | input | 960 | Word address of lane i in bits [30*i+29:30*i] |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Memory side takes the transaction |
| txn_base | output | 32 | Segment byte address |
| txn_be | output | 128 | Byte enables within the segment |
| done | output | 1 | Last transaction of the instruction accepted |

## Verification
The main function is tried with several address patterns:
- An aligned 32-word run, which must give one full-enable transaction.
- The same run shifted off the boundary, which must split in two.
- A 32-word stride, which must give one transaction per lane.
- A broadcast of a single address, which must give one transaction with a single enabled word.
- A reversed layout, where the lowest lane sits in the highest segment, which separates lane-order emission from address-order emission.
- Partial and empty masks, which expose leakage from inactive lanes.

Random instructions spread over a few nearby segments follow. They run under random back-pressure, which checks holding and done timing against a bench model of the grouping.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES = 32,
  parameter int WAW = 30,
  parameter int SEG_BYTES = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [LANES-1:0]       req_mask,
  input  logic [LANES*WAW-1:0]   req_waddr,
  output logic                   txn_valid,
  input  logic                   txn_ready,
  output logic [WAW+1:0]         txn_base,
  output logic [SEG_BYTES-1:0]   txn_be,
  output logic                   done
);
  localparam int WPS = SEG_BYTES / 4;
  localparam int WB  = $clog2(WPS);
  localparam int SW  = WAW - WB;

  logic                 busy;
  logic [LANES-1:0]     pend;
  logic [LANES*WAW-1:0] addr_q;
  logic [LANES-1:0]     match;
  logic [SW-1:0]        lead_seg;
  logic                 found;

  always_comb begin
    found = 1'b0;
    lead_seg = '0;
    for (int i = 0; i < LANES; i++)
      if (pend[i] && !found) begin
        found = 1'b1;
        lead_seg = addr_q[i*WAW+WB +: SW];
      end
    txn_be = '0;
    for (int i = 0; i < LANES; i++) begin
      match[i] = pend[i] && (addr_q[i*WAW+WB +: SW] == lead_seg);
      if (match[i]) txn_be[{addr_q[i*WAW +: WB], 2'b00} +: 4] = 4'hF;
    end
  end

  assign req_ready = !busy;
  assign txn_valid = busy && (pend != '0);
  assign txn_base  = {lead_seg, {(WB+2){1'b0}}};

  wire accept = req_valid && req_ready;
  wire fire   = txn_valid && txn_ready;
  wire last   = fire && ((pend & ~match) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pend   <= '0;
      addr_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= (accept && req_mask == '0) || last;
      if (accept) begin
        busy   <= (req_mask != '0);
        pend   <= req_mask;
        addr_q <= req_waddr;
      end else if (fire) begin
        pend <= pend & ~match;
        if (last) busy <= 1'b0;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_be));
  p_be_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> txn_be != '0);
  p_no_take_while_sending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid && req_ready);
  p_fire_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !last |=> $countones(pend) < $countones($past(pend)));
endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int L = 32;
  localparam int W = 30;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [L-1:0] req_mask = '0;
  logic [L*W-1:0] req_waddr = '0;
  logic txn_valid;
  logic txn_ready = 0;
  logic [W+1:0] txn_base;
  logic [127:0] txn_be;
  logic done;

  always #2.5 clk = ~clk;

  warp_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .req_waddr(req_waddr), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_base(txn_base), .txn_be(txn_be), .done(done)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] la [L];
  logic [W+1:0] eb [L];
  logic [127:0] ee [L];
  int en;
  int seen;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [L-1:0] m);
    logic [L-1:0] rem;
    logic [W-5-1:0] seg;
    rem = m;
    en = 0;
    while (rem != '0) begin
      int lo;
      lo = 0;
      for (int i = L-1; i >= 0; i--) if (rem[i]) lo = i;
      seg = la[lo][W-1:5];
      ee[en] = '0;
      eb[en] = {seg, 7'b0};
      for (int j = 0; j < L; j++)
        if (rem[j] && la[j][W-1:5] == seg) begin
          ee[en][la[j][4:0]*4 +: 4] = 4'hF;
          rem[j] = 1'b0;
        end
      en++;
    end
  endtask

  task automatic run(input logic [L-1:0] m, input int stall_pct);
    int k;
    bit prev_last;
    int guard;
    model(m);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before instr", 128'(req_ready), 128'd1);
    for (int i = 0; i < L; i++) req_waddr[i*W +: W] = la[i];
    req_mask = m;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    k = 0;
    prev_last = (en == 0);
    guard = 0;
    seen = 0;
    forever begin
      chk(done == prev_last, "R9 done timing", 128'(done), 128'(prev_last));
      if (prev_last) break;
      if (guard++ > 2000) begin
        chk(1'b0, "R9 no done", 0, 1);
        break;
      end
      chk(req_ready == 1'b0, "R2 busy", 128'(req_ready), 0);
      txn_ready = (($urandom % 100) >= stall_pct);
      if (txn_valid) begin
        if (k < en) begin
          chk(txn_base == eb[k], "R7 R10 base", 128'(txn_base), 128'(eb[k]));
          chk(txn_be == ee[k], "R5 R6 R8 be", txn_be, ee[k]);
        end else chk(1'b0, "R6 extra transaction", 128'(k), 128'(en));
        if (txn_ready) begin
          k++;
          seen++;
          prev_last = (k >= en);
        end
      end else prev_last = 0;
      @(negedge clk);
    end
    txn_ready = 0;
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(txn_valid == 0 && done == 0 && req_ready == 1, "R1 reset state",
        {txn_valid, done, req_ready}, 3'b001);
    rst_n = 1;
    // R3 aligned run
    for (int i = 0; i < L; i++) la[i] = 30'h400 + i;
    run('1, 0);
    chk(seen == 1, "R3 one transaction", seen, 1);
    run('1, 50);
    chk(seen == 1, "R3 with stalls", seen, 1);
    // R4 misaligned run
    for (int i = 0; i < L; i++) la[i] = 30'h410 + i;
    run('1, 30);
    chk(seen == 2, "R4 two transactions", seen, 2);
    // fully scattered
    for (int i = 0; i < L; i++) la[i] = 30'h800 + i*32;
    run('1, 20);
    chk(seen == 32, "R7 scattered", seen, 32);
    // broadcast
    for (int i = 0; i < L; i++) la[i] = 30'h123;
    run('1, 0);
    chk(seen == 1, "R5 broadcast merged", seen, 1);
    // reversed: lane 0 highest segment
    for (int i = 0; i < L; i++) la[i] = 30'h2000 + (L-1-i)*32 + 3;
    run('1, 10);
    chk(seen == 32, "R7 reversed", seen, 32);
    // empty mask
    run('0, 0);
    chk(seen == 0, "R6 empty mask", seen, 0);
    // partial mask: inactive lanes in other segments
    for (int i = 0; i < L; i++) la[i] = (i % 2) ? 30'h5000 + i*64 : 30'h600 + i;
    run(32'h5555_5555, 0);
    chk(seen == 1, "R6 inactive lanes ignored", seen, 1);
    // random
    for (int t = 0; t < 60; t++) begin
      logic [L-1:0] m;
      for (int i = 0; i < L; i++) la[i] = 30'h1000 + ($urandom % 160);
      m = $urandom;
      if (t % 7 == 0) m = '1;
      run(m, $urandom % 60);
      chk(seen == en, "R7 random count", seen, en);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule